// File: doc/BRIEF.md
# DRAM Bank Access Sequencer with Wait Input

This block turns a single internal access request into the strobe sequence for one of two 16-bit DRAM banks. A request carries the bank number, the row and column addresses, the direction, two byte-lane enables and the write data. The sequencer puts the row address on a shared multiplexed address bus and lowers that bank's RAS. It then switches the bus to the column address and drives the column strobes. After the column phase and one precharge cycle it reports completion.

Three shared strobe pins change meaning per bank through a byte-access mode bit. In scheme 0 they carry one write enable and two per-lane column strobes. In scheme 1 they carry two per-lane write enables and one column strobe. The column phase is stretched by a programmable count of wait cycles. If the external active-low wait input is enabled for the bank, the phase is stretched further, by one cycle for every clock edge at which that input is seen low once the count has run out.

Top module: `dram_seq`

## Requirements
- R1: After reset the block is idle: every `ras_n` bit and all three strobe pins are 1, `busy` and `done` are 0 and `dq_oe` is 0.
- R2: A request is accepted at a rising edge where `req_valid` is 1 and `busy` is 0. The next cycle is the row cycle: `mem_addr` carries the row, the bank's RAS is low and all three strobe pins are still 1. The cycle after that is the first column cycle, with `mem_addr` carrying the column.
- R3: With the wait input not honoured, the column phase lasts exactly 1 + N cycles, where N is `cfg_wait_cnt` at acceptance.
- R4: With the wait input enabled for the bank, the column phase gains one cycle for every rising edge at which `ext_wait_n` is sampled 0 after the N counted cycles. The wait input stays honoured for as long as it is held low, with no timeout.
- R5: With the wait input disabled for the bank (`cfg_wait_en[bank]`=0), `ext_wait_n` has no effect on the length of the column phase.
- R6: Scheme 0 (`cfg_byte_mode[bank]`=0): in column cycles `pin_a_n` is the shared write enable (low only for writes), `pin_b_n` is the high-lane column strobe (low if `req_be[1]`=1) and `pin_c_n` is the low-lane column strobe (low if `req_be[0]`=1).
- R7: Scheme 1 (`cfg_byte_mode[bank]`=1): in column cycles `pin_c_n` is the shared column strobe (low for every access), `pin_a_n` is the low-lane write enable and `pin_b_n` is the high-lane write enable. Each write enable is low only for a write with that lane's enable set.
- R8: Only the addressed bank's RAS is ever low (`ras_n[bank]`, bank 0 in bit 0). It stays low through the row cycle and all column cycles.
- R9: After the last column cycle comes one precharge cycle, in which all strobes are 1 and `done` is 1 for exactly that cycle. For a read, `rd_data` then holds `dq_in` as sampled at the edge that ends the last column cycle. In the next cycle `busy` is 0.
- R10: Wait count, wait enable and byte mode are taken at acceptance. Changing `cfg_*` during an access does not alter that access.
- R11: During column cycles of a write, `dq_oe` is 1 and `dq_out` equals the request's write data. For reads, and outside column cycles, `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, taken when idle |
| req_bank | input | 1 | Target bank |
| req_row | input | 16 | Row address |
| req_col | input | 16 | Column address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane enables, bit 1 high lane |
| req_wdata | input | 16 | Write data |
| cfg_wait_cnt | input | 4 | Programmed wait cycles in the column phase |
| cfg_wait_en | input | 2 | Per-bank enable for the external wait input |
| cfg_byte_mode | input | 2 | Per-bank strobe scheme select |
| ext_wait_n | input | 1 | External wait request, active low, synchronous |
| dq_in | input | 16 | Read data from the memory |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read data |
| mem_addr | output | 16 | Multiplexed row/column address |
| ras_n | output | 2 | Per-bank row strobe, active low |
| pin_a_n | output | 1 | Shared write enable or low-lane write enable |
| pin_b_n | output | 1 | High-lane column strobe or high-lane write enable |
| pin_c_n | output | 1 | Low-lane column strobe or shared column strobe |
| dq_out | output | 16 | Write data to the memory |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The bench sweeps both banks, both strobe schemes, reads and writes, all four byte-enable patterns, wait counts of 0, 1 and 3, and the wait input held low for zero or two sampled edges, each with that input enabled and disabled. Comparing the enabled and disabled runs under the same held-low wait input separates honouring from ignoring. The empty and single-lane enable patterns show which pin belongs to which lane in each scheme. The zero wait count catches an off-by-one in the column phase. During every access the configuration inputs are flipped to other values, so a design that reads them live gives wrong strobes or a wrong length.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_COL  = 2'd2,
        ST_PRE  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
    import dram_seq_pkg::*;
#(
    parameter int NBANK = 2,
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int WCW   = 4,
    localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int NLANE = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [BW-1:0]    req_bank,
    input  logic [AW-1:0]    req_row,
    input  logic [AW-1:0]    req_col,
    input  logic             req_write,
    input  logic [NLANE-1:0] req_be,
    input  logic [DW-1:0]    req_wdata,
    input  logic [WCW-1:0]   cfg_wait_cnt,
    input  logic [NBANK-1:0] cfg_wait_en,
    input  logic [NBANK-1:0] cfg_byte_mode,
    input  logic             ext_wait_n,
    input  logic [DW-1:0]    dq_in,
    output seq_state_e       state_o,
    output logic [BW-1:0]    bank_o,
    output logic [AW-1:0]    row_o,
    output logic [AW-1:0]    col_o,
    output logic             wr_o,
    output logic [NLANE-1:0] be_o,
    output logic [DW-1:0]    wdata_o,
    output logic             mode_o,
    output logic [DW-1:0]    rdata_o
);

    typedef struct packed {
        seq_state_e       state;
        logic [BW-1:0]    bank;
        logic [AW-1:0]    row;
        logic [AW-1:0]    col;
        logic             wr;
        logic [NLANE-1:0] be;
        logic [DW-1:0]    wdata;
        logic [WCW-1:0]   wcnt;
        logic             mode;
        logic             wen;
        logic [DW-1:0]    rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.state = ST_ROW;
                    ctl_d.bank  = req_bank;
                    ctl_d.row   = req_row;
                    ctl_d.col   = req_col;
                    ctl_d.wr    = req_write;
                    ctl_d.be    = req_be;
                    ctl_d.wdata = req_wdata;
                    ctl_d.wcnt  = cfg_wait_cnt;
                    ctl_d.mode  = cfg_byte_mode[req_bank];
                    ctl_d.wen   = cfg_wait_en[req_bank];
                end
            end
            ST_ROW: ctl_d.state = ST_COL;
            ST_COL: begin
                if (ctl_q.wcnt != '0) begin
                    ctl_d.wcnt = ctl_q.wcnt - WCW'(1);
                end else if (ctl_q.wen && !ext_wait_n) begin
                    ctl_d.state = ST_COL;
                end else begin
                    ctl_d.state = ST_PRE;
                    if (!ctl_q.wr) ctl_d.rdata = dq_in;
                end
            end
            ST_PRE: ctl_d.state = ST_IDLE;
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state_o = ctl_q.state;
    assign bank_o  = ctl_q.bank;
    assign row_o   = ctl_q.row;
    assign col_o   = ctl_q.col;
    assign wr_o    = ctl_q.wr;
    assign be_o    = ctl_q.be;
    assign wdata_o = ctl_q.wdata;
    assign mode_o  = ctl_q.mode;
    assign rdata_o = ctl_q.rdata;

    // R3: programmed wait cycles count down one per column cycle
    a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_COL && ctl_q.wcnt != '0)
        |=> (ctl_q.state == ST_COL && ctl_q.wcnt == $past(ctl_q.wcnt) - WCW'(1)));

    // R4: a sampled-low wait input holds the column phase when enabled
    a_r4_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_COL && ctl_q.wcnt == '0 && ctl_q.wen && !ext_wait_n)
        |=> (ctl_q.state == ST_COL));

    // R5: a disabled wait input never holds the column phase
    a_r5_wait_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_COL && ctl_q.wcnt == '0 && !ctl_q.wen)
        |=> (ctl_q.state == ST_PRE));

    // R2: the row cycle always leads into the column phase
    a_r2_row_then_col: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_ROW) |=> (ctl_q.state == ST_COL && $stable(ctl_q.col)));

endmodule

// File: rtl/dram_seq_pins.sv
module dram_seq_pins
    import dram_seq_pkg::*;
#(
    parameter int NBANK = 2,
    parameter int AW    = 16,
    parameter int DW    = 16,
    localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int NLANE = DW / 8
) (
    input  seq_state_e       state,
    input  logic [BW-1:0]    bank,
    input  logic [AW-1:0]    row,
    input  logic [AW-1:0]    col,
    input  logic             wr,
    input  logic [NLANE-1:0] be,
    input  logic [DW-1:0]    wdata,
    input  logic             mode,
    output logic [AW-1:0]    mem_addr,
    output logic [NBANK-1:0] ras_n,
    output logic             pin_a_n,
    output logic             pin_b_n,
    output logic             pin_c_n,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe
);

    logic row_open;
    assign row_open = (state == ST_ROW) || (state == ST_COL);

    for (genvar g = 0; g < NBANK; g++) begin : g_ras
        assign ras_n[g] = !(row_open && (bank == BW'(g)));
    end

    always_comb begin
        mem_addr = '0;
        pin_a_n  = 1'b1;
        pin_b_n  = 1'b1;
        pin_c_n  = 1'b1;
        dq_oe    = 1'b0;
        if (state == ST_ROW) begin
            mem_addr = row;
        end
        if (state == ST_COL) begin
            mem_addr = col;
            dq_oe    = wr;
            if (!mode) begin
                pin_a_n = !wr;
                pin_b_n = !be[NLANE-1];
                pin_c_n = !be[0];
            end else begin
                pin_a_n = !(wr && be[0]);
                pin_b_n = !(wr && be[NLANE-1]);
                pin_c_n = 1'b0;
            end
        end
    end

    assign dq_out = wdata;

endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_seq_pkg::*;
#(
    parameter int NBANK = 2,
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int WCW   = 4,
    localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int NLANE = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [BW-1:0]    req_bank,
    input  logic [AW-1:0]    req_row,
    input  logic [AW-1:0]    req_col,
    input  logic             req_write,
    input  logic [NLANE-1:0] req_be,
    input  logic [DW-1:0]    req_wdata,
    input  logic [WCW-1:0]   cfg_wait_cnt,
    input  logic [NBANK-1:0] cfg_wait_en,
    input  logic [NBANK-1:0] cfg_byte_mode,
    input  logic             ext_wait_n,
    input  logic [DW-1:0]    dq_in,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rd_data,
    output logic [AW-1:0]    mem_addr,
    output logic [NBANK-1:0] ras_n,
    output logic             pin_a_n,
    output logic             pin_b_n,
    output logic             pin_c_n,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe
);

    seq_state_e       st;
    logic [BW-1:0]    cur_bank;
    logic [AW-1:0]    cur_row;
    logic [AW-1:0]    cur_col;
    logic             cur_wr;
    logic [NLANE-1:0] cur_be;
    logic [DW-1:0]    cur_wdata;
    logic             cur_mode;

    dram_seq_ctrl #(.NBANK(NBANK), .AW(AW), .DW(DW), .WCW(WCW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_bank     (req_bank),
        .req_row      (req_row),
        .req_col      (req_col),
        .req_write    (req_write),
        .req_be       (req_be),
        .req_wdata    (req_wdata),
        .cfg_wait_cnt (cfg_wait_cnt),
        .cfg_wait_en  (cfg_wait_en),
        .cfg_byte_mode(cfg_byte_mode),
        .ext_wait_n   (ext_wait_n),
        .dq_in        (dq_in),
        .state_o      (st),
        .bank_o       (cur_bank),
        .row_o        (cur_row),
        .col_o        (cur_col),
        .wr_o         (cur_wr),
        .be_o         (cur_be),
        .wdata_o      (cur_wdata),
        .mode_o       (cur_mode),
        .rdata_o      (rd_data)
    );

    dram_seq_pins #(.NBANK(NBANK), .AW(AW), .DW(DW)) u_pins (
        .state   (st),
        .bank    (cur_bank),
        .row     (cur_row),
        .col     (cur_col),
        .wr      (cur_wr),
        .be      (cur_be),
        .wdata   (cur_wdata),
        .mode    (cur_mode),
        .mem_addr(mem_addr),
        .ras_n   (ras_n),
        .pin_a_n (pin_a_n),
        .pin_b_n (pin_b_n),
        .pin_c_n (pin_c_n),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe)
    );

    assign busy = (st != ST_IDLE);
    assign done = (st == ST_PRE);

    // R8: at most one row strobe low at any time
    a_r8_one_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ras_n));

    // R2: a row strobe falls while all three shared strobes are still high
    a_r2_ras_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(&ras_n) |-> (pin_a_n && pin_b_n && pin_c_n));

    // R9: completion lasts one cycle and is followed by idle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R1: when idle, every strobe is inactive and the data bus is released
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&ras_n && pin_a_n && pin_b_n && pin_c_n && !dq_oe));

endmodule

// File: tb/tb_dram_seq.sv
module tb_dram_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [0:0]  req_bank = '0;
    logic [15:0] req_row = '0;
    logic [15:0] req_col = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  cfg_wait_cnt = '0;
    logic [1:0]  cfg_wait_en = '0;
    logic [1:0]  cfg_byte_mode = '0;
    logic        ext_wait_n = 1'b1;
    logic [15:0] dq_in = '0;
    logic        busy, done, pin_a_n, pin_b_n, pin_c_n, dq_oe;
    logic [15:0] rd_data, mem_addr, dq_out;
    logic [1:0]  ras_n;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dram_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .req_write(req_write),
        .req_be(req_be), .req_wdata(req_wdata), .cfg_wait_cnt(cfg_wait_cnt),
        .cfg_wait_en(cfg_wait_en), .cfg_byte_mode(cfg_byte_mode),
        .ext_wait_n(ext_wait_n), .dq_in(dq_in), .busy(busy), .done(done),
        .rd_data(rd_data), .mem_addr(mem_addr), .ras_n(ras_n),
        .pin_a_n(pin_a_n), .pin_b_n(pin_b_n), .pin_c_n(pin_c_n),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // pins packed as {a,b,c}
    function automatic logic [2:0] col_pins(input bit mode, input bit wr,
                                            input logic [1:0] be);
        if (!mode) return {!wr, !be[1], !be[0]};
        return {!(wr && be[0]), !(wr && be[1]), 1'b0};
    endfunction

    task automatic access(input bit bank, input bit mode, input bit wr,
                          input logic [1:0] be, input int nwait, input int nlow,
                          input bit wen, input int idx);
        logic [15:0] row, col, wd, pat;
        logic [2:0]  pexp;
        logic [1:0]  rexp;
        int          len;
        row  = 16'h0100 * idx[15:0] + 16'h0035;
        col  = ~row;
        wd   = row ^ 16'h5A5A;
        pat  = {bank, mode, wr, 13'h0} ^ row;
        pexp = col_pins(mode, wr, be);
        rexp = bank ? 2'b01 : 2'b10;
        len  = 1 + nwait + (wen ? nlow : 0);

        @(negedge clk);
        req_valid = 1'b1;
        req_bank  = bank;
        req_row   = row;
        req_col   = col;
        req_write = wr;
        req_be    = be;
        req_wdata = wd;
        cfg_wait_cnt  = nwait[3:0];
        cfg_wait_en   = wen ? (bank ? 2'b10 : 2'b01) : (bank ? 2'b01 : 2'b10);
        cfg_byte_mode = mode ? (bank ? 2'b10 : 2'b01) : (bank ? 2'b01 : 2'b10);

        @(negedge clk);
        req_valid = 1'b0;
        // R10: flip every configuration field after acceptance
        cfg_wait_cnt  = nwait[3:0] ^ 4'hA;
        cfg_wait_en   = ~cfg_wait_en;
        cfg_byte_mode = ~cfg_byte_mode;
        check(mem_addr == row, "R2 row address", mem_addr, row);
        check(ras_n == rexp, "R8 row cycle ras", ras_n, rexp);
        check({pin_a_n, pin_b_n, pin_c_n} == 3'b111, "R2 strobes high in row cycle",
              {pin_a_n, pin_b_n, pin_c_n}, 3'b111);
        check(busy && !done, "R2 busy in row cycle", {busy, done}, 2'b10);

        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            ext_wait_n = (k >= nwait && k < nwait + nlow) ? 1'b0 : 1'b1;
            dq_in      = pat ^ k[15:0];
            check(mem_addr == col && !done, "R3 column cycle address / no early done",
                  {done, mem_addr}, {1'b0, col});
            check(ras_n == rexp, "R8 column cycle ras", ras_n, rexp);
            check({pin_a_n, pin_b_n, pin_c_n} == pexp,
                  mode ? "R7 scheme 1 strobes R10" : "R6 scheme 0 strobes R10",
                  {pin_a_n, pin_b_n, pin_c_n}, pexp);
            check(dq_oe == wr && (!wr || dq_out == wd), "R11 write data drive",
                  {dq_oe, dq_out}, {wr, wd});
        end

        @(negedge clk);
        ext_wait_n = 1'b1;
        check(done, wen ? "R4 column phase length with wait" : "R5 wait ignored length",
              done, 1'b1);
        check(ras_n == 2'b11 && {pin_a_n, pin_b_n, pin_c_n} == 3'b111 && !dq_oe,
              "R9 precharge strobes high", {ras_n, pin_a_n, pin_b_n, pin_c_n, dq_oe},
              6'b111110);
        if (!wr)
            check(rd_data == (pat ^ 16'(len - 1)), "R9 read data capture",
                  rd_data, pat ^ 16'(len - 1));

        @(negedge clk);
        check(!busy && !done, "R9 idle after precharge", {busy, done}, 2'b00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R4 watchdog expired actual=hung expected=finished");
        summary();
    end

    initial begin
        int idx;
        idx = 0;
        repeat (2) @(negedge clk);
        check(ras_n == 2'b11 && {pin_a_n, pin_b_n, pin_c_n} == 3'b111,
              "R1 reset strobes", {ras_n, pin_a_n, pin_b_n, pin_c_n}, 5'b11111);
        check(!busy && !done && !dq_oe, "R1 reset status", {busy, done, dq_oe}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R1 idle after reset release", busy, 1'b0);

        for (int b = 0; b < 2; b++)
            for (int m = 0; m < 2; m++)
                for (int w = 0; w < 2; w++)
                    for (int e = 0; e < 4; e++)
                        for (int nw = 0; nw < 3; nw++)
                            for (int nl = 0; nl < 2; nl++)
                                for (int en = 0; en < 2; en++) begin
                                    access(b[0], m[0], w[0], e[1:0],
                                           (nw == 2) ? 3 : nw, nl * 2, en[0], idx);
                                    idx++;
                                end

        // R4: a long held wait input keeps stretching the access
        access(1'b0, 1'b1, 1'b0, 2'b11, 0, 20, 1'b1, idx);
        summary();
    end

endmodule